// File: doc/BRIEF.md
# Buzzer Melody Player

This block drives a passive buzzer with a square wave whose period, counted in system clock cycles, comes from a note code. It plays one of two tunes. The first is a fixed 16-step chime that an hourly pulse starts. The second is a note list that a host sends as bytes from a UART receiver after it issues an alarm command. A sequencer holds each note for a fixed number of clock cycles and passes its period to a PWM stage. A note code of zero gives a silent step.

A received tune is stored in a small note buffer. Loading stops when a terminator byte arrives or when the buffer fills. The stored notes then play in order. For exactly as long as that playback lasts, the block holds a freeze flag high so that a display can stop refreshing. The chime never raises the flag. Received tunes take precedence: a chime request arriving while a tune loads or plays is dropped, and an alarm command cuts a chime short.

Top module: `buzz_player`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, `buzz_o` and `freeze_o` are low.
- R2: For a note of period P cycles, `buzz_o` repeats every P cycles and is high for (P>>1)-1 cycles of each period. The wave restarts low at every step boundary.
- R3: A note code is 4 bits, taken from the low nibble of a received byte. Codes 1 to 7 select periods 19389, 17256, 15358, 13669, 12895, 11477 and 10215 cycles. Codes 8 to 14 select half of the period of codes 1 to 7 in the same order (code 13 gives 5738, code 14 gives 5107). Codes 0 and 15 are rests, during which `buzz_o` stays low.
- R4: A one-cycle `chime_i` pulse in the idle state starts the built-in tune. The tune has 16 steps of 2^STEP_LOG2 cycles each, and `freeze_o` stays low throughout.
- R5: The chime stops after CHIME_MAX cycles even if its 16 steps are not finished. After that, `buzz_o` stays low.
- R6: An `alarm_i` pulse in the idle state starts loading. Each byte presented with `rx_valid_i` is stored in arrival order. A byte of 0xFF ends loading and playback begins.
- R7: When DEPTH notes have been stored, playback begins without a terminator. Bytes that arrive during playback are ignored.
- R8: `freeze_o` rises on the clock edge that accepts the final byte. It stays high for exactly N x 2^STEP_LOG2 cycles for N stored notes, then falls.
- R9: During loading or playback, `chime_i` and `alarm_i` have no effect. Playback length is unchanged, and no chime sounds afterwards.
- R10: An `alarm_i` pulse during a chime ends the chime and starts loading.
- R11: A 0xFF byte received before any note returns the block to idle without raising `freeze_o`. Later bytes are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chime_i | input | 1 | One-cycle hourly chime request |
| alarm_i | input | 1 | One-cycle host alarm command; starts tune loading |
| rx_valid_i | input | 1 | Received byte is valid this cycle |
| rx_data_i | input | 8 | Received byte: note code in bits 3:0, 0xFF ends the tune |
| buzz_o | output | 1 | Square wave to the passive buzzer |
| freeze_o | output | 1 | High while a received tune plays; display holds its contents |

## Verification
The bench measures the wave period and the high time of received notes, and checks that a rest step in the middle of a tune stays silent. A wrong period lookup or duty compare shows up as a measured interval or pulse width that is off. It also measures the freeze flag's width to the cycle for a terminated tune and for a tune that fills the buffer. An off-by-one in the step counter or the length register would stretch or shorten the flag by a whole step. Further cases are a chime that outlasts CHIME_MAX, a chime or alarm arriving mid-playback, an alarm that cuts into a chime, and a terminator with an empty buffer. Each of these would show as late tones, a shortened freeze, or a block stuck in loading that starts a tune from stray bytes.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHIME = 2'd1,
    ST_LOAD  = 2'd2,
    ST_PLAY  = 2'd3
  } play_st_t;

  localparam int PER_W  = 16;
  localparam int CODE_W = 4;

  // lower-octave periods in 12 MHz clock cycles
  function automatic logic [PER_W-1:0] base_period(input logic [2:0] k);
    case (k)
      3'd1:    base_period = 16'd19389;
      3'd2:    base_period = 16'd17256;
      3'd3:    base_period = 16'd15358;
      3'd4:    base_period = 16'd13669;
      3'd5:    base_period = 16'd12895;
      3'd6:    base_period = 16'd11477;
      3'd7:    base_period = 16'd10215;
      default: base_period = '0;
    endcase
  endfunction

  // 0 and 15 are rests, 1..7 lower octave, 8..14 upper octave (half period)
  function automatic logic [PER_W-1:0] tone_period(input logic [CODE_W-1:0] code);
    if (code == 4'd0 || code == 4'd15)
      tone_period = '0;
    else if (!code[3])
      tone_period = base_period(code[2:0]);
    else
      tone_period = base_period(code[2:0] + 3'd1) >> 1;
  endfunction

  // fixed chime melody, one code per step
  function automatic logic [CODE_W-1:0] chime_code(input logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd14:         chime_code = 4'd1;
      4'd2, 4'd3, 4'd6:          chime_code = 4'd5;
      4'd4, 4'd5:                chime_code = 4'd6;
      4'd8, 4'd9:                chime_code = 4'd4;
      4'd10, 4'd11:              chime_code = 4'd3;
      4'd12, 4'd13:              chime_code = 4'd2;
      default:                   chime_code = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/buzz_note_buf.sv
module buzz_note_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/buzz_pwm.sv
module buzz_pwm #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             wave_q
);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] duty;
  logic             en;

  assign duty = period >> 1;
  assign en   = (period != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= PER_W'(1);
      wave_q <= 1'b0;
    end else if (!en || restart) begin
      cnt    <= PER_W'(1);
      wave_q <= 1'b0;
    end else begin
      if (cnt >= period) cnt <= PER_W'(1);
      else               cnt <= cnt + PER_W'(1);
      wave_q <= (cnt < duty);
    end
  end

endmodule

// File: rtl/buzz_seq.sv
module buzz_seq
  import buzz_pkg::*;
#(
  parameter int STEP_LOG2 = 22,
  parameter int DEPTH     = 64,
  parameter int CHIME_MAX = 360_000_000,
  localparam int AW       = $clog2(DEPTH),
  localparam int CT_W     = $clog2(CHIME_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chime_i,
  input  logic              alarm_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              buf_we,
  output logic [AW-1:0]     buf_waddr,
  output logic [CODE_W-1:0] buf_wdata,
  output logic [AW-1:0]     buf_raddr,
  input  logic [CODE_W-1:0] buf_rdata,
  output play_st_t          st_o,
  output logic [PER_W-1:0]  period_o,
  output logic              restart_o,
  output logic              freeze_o
);

  play_st_t             st, st_nxt;
  logic [STEP_LOG2-1:0] step_cnt;
  logic [3:0]           chime_idx;
  logic [CT_W-1:0]      chime_tot;
  logic [AW:0]          wptr;
  logic [AW:0]          len;
  logic [AW-1:0]        rd, rd_nxt;
  logic                 step_end, is_term, last_slot, last_note, chime_done;

  assign step_end   = &step_cnt;
  assign is_term    = (rx_data_i == 8'hFF);
  assign last_slot  = (wptr == (AW+1)'(DEPTH - 1));
  assign last_note  = ({1'b0, rd} == len - (AW+1)'(1));
  assign chime_done = (step_end && chime_idx == 4'd15) ||
                      (chime_tot == CT_W'(CHIME_MAX - 1));

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:  if (alarm_i) st_nxt = ST_LOAD;
                else if (chime_i) st_nxt = ST_CHIME;
      ST_CHIME: if (alarm_i) st_nxt = ST_LOAD;
                else if (chime_done) st_nxt = ST_IDLE;
      ST_LOAD:  if (rx_valid_i) begin
                  if (is_term) st_nxt = (wptr == '0) ? ST_IDLE : ST_PLAY;
                  else if (last_slot) st_nxt = ST_PLAY;
                end
      ST_PLAY:  if (step_end && last_note) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st != ST_PLAY) rd_nxt = '0;
    else if (step_end) rd_nxt = rd + AW'(1);
    else               rd_nxt = rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      step_cnt  <= '0;
      chime_idx <= '0;
      chime_tot <= '0;
      wptr      <= '0;
      len       <= '0;
      rd        <= '0;
      freeze_o  <= 1'b0;
    end else begin
      st       <= st_nxt;
      rd       <= rd_nxt;
      freeze_o <= (st_nxt == ST_PLAY);

      if (st_nxt != st || !(st == ST_CHIME || st == ST_PLAY)) step_cnt <= '0;
      else step_cnt <= step_cnt + STEP_LOG2'(1);

      if (st_nxt != st)                chime_tot <= '0;
      else if (st == ST_CHIME)         chime_tot <= chime_tot + CT_W'(1);

      if (st_nxt == ST_CHIME && st != ST_CHIME) chime_idx <= '0;
      else if (st == ST_CHIME && step_end)      chime_idx <= chime_idx + 4'd1;

      if (st_nxt == ST_LOAD && st != ST_LOAD)   wptr <= '0;
      else if (buf_we)                          wptr <= wptr + (AW+1)'(1);

      if (st == ST_LOAD && st_nxt == ST_PLAY)
        len <= is_term ? wptr : wptr + (AW+1)'(1);
    end
  end

  assign buf_we    = (st == ST_LOAD) && rx_valid_i && !is_term;
  assign buf_waddr = wptr[AW-1:0];
  assign buf_wdata = rx_data_i[CODE_W-1:0];
  assign buf_raddr = rd_nxt;

  always_comb begin
    case (st)
      ST_PLAY:  period_o = tone_period(buf_rdata);
      ST_CHIME: period_o = tone_period(chime_code(chime_idx));
      default:  period_o = '0;
    endcase
  end

  assign restart_o = (step_cnt == '0);
  assign st_o      = st;

endmodule

// File: rtl/buzz_player.sv
module buzz_player
  import buzz_pkg::*;
#(
  parameter int STEP_LOG2 = 22,
  parameter int DEPTH     = 64,
  parameter int CHIME_MAX = 360_000_000,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chime_i,
  input  logic       alarm_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       buzz_o,
  output logic       freeze_o
);

  logic              buf_we;
  logic [AW-1:0]     buf_waddr, buf_raddr;
  logic [CODE_W-1:0] buf_wdata, buf_rdata;
  play_st_t          st;
  logic [PER_W-1:0]  period;
  logic              restart;

  buzz_seq #(
    .STEP_LOG2 (STEP_LOG2),
    .DEPTH     (DEPTH),
    .CHIME_MAX (CHIME_MAX)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .chime_i    (chime_i),
    .alarm_i    (alarm_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_wdata  (buf_wdata),
    .buf_raddr  (buf_raddr),
    .buf_rdata  (buf_rdata),
    .st_o       (st),
    .period_o   (period),
    .restart_o  (restart),
    .freeze_o   (freeze_o)
  );

  buzz_note_buf #(
    .DEPTH (DEPTH),
    .DW    (CODE_W)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  buzz_pwm #(
    .PER_W (PER_W)
  ) u_pwm (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .period  (period),
    .wave_q  (buzz_o)
  );

endmodule

// File: rtl/buzz_player_chk.sv
module buzz_player_chk
  import buzz_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             chime_i,
  input logic             buzz_o,
  input logic             freeze_o,
  input play_st_t         st,
  input logic [PER_W-1:0] period
);

  // R1: outputs quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!buzz_o && !freeze_o));

  // R3: a rest or idle period forces the wave low on the next cycle
  assert_rest_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> !buzz_o);

  // R8: freeze only starts out of the loading phase
  assert_freeze_from_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_o) |-> ($past(st) == ST_LOAD));

  // R8: once freeze drops the buzzer goes silent
  assert_silent_after_play_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze_o) |=> !buzz_o);

  // R9: a chime request during playback keeps the block in playback or idle
  assert_chime_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PLAY && chime_i) |=> (st != ST_CHIME));

endmodule

bind buzz_player buzz_player_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .chime_i  (chime_i),
  .buzz_o   (buzz_o),
  .freeze_o (freeze_o),
  .st       (st),
  .period   (period)
);

// File: tb/buzz_player_test.sv
module buzz_player_test;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_LOG2  = 13;
  localparam int STEP       = 1 << STEP_LOG2;
  localparam int DEPTH      = 4;
  localparam int CHIME_MAX  = 20000;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chime_i = 1'b0;
  logic       alarm_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       buzz_o, freeze_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int rises [64];
  int n_rise;
  int first_fall;
  int rest_highs;

  buzz_player #(
    .STEP_LOG2 (STEP_LOG2),
    .DEPTH     (DEPTH),
    .CHIME_MAX (CHIME_MAX)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .chime_i    (chime_i),
    .alarm_i    (alarm_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .buzz_o     (buzz_o),
    .freeze_o   (freeze_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_alarm();
    @(negedge clk) alarm_i = 1'b1;
    @(negedge clk) alarm_i = 1'b0;
  endtask

  task automatic pulse_chime();
    @(negedge clk) chime_i = 1'b1;
    @(negedge clk) chime_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin rx_valid_i = 1'b1; rx_data_i = b; end
    @(negedge clk) rx_valid_i = 1'b0;
  endtask

  // records wave edges from the first cycle freeze is seen high until it drops
  task automatic watch_play(output int width);
    int t;
    logic prev;
    n_rise = 0; first_fall = -1; rest_highs = 0; width = 0;
    t = 0;
    while (!freeze_o && t < 50) begin @(negedge clk); t++; end
    if (!freeze_o) return;
    prev = buzz_o;
    t = 0;
    while (freeze_o) begin
      if (buzz_o && !prev && n_rise < 64) begin rises[n_rise] = t; n_rise++; end
      if (!buzz_o && prev && first_fall < 0) first_fall = t;
      if (t >= STEP + 4 && t < 2*STEP && buzz_o) rest_highs++;
      prev = buzz_o;
      @(negedge clk);
      t++;
    end
    width = t;
  endtask

  function automatic int period_from(input int lo);
    for (int i = 0; i + 1 < n_rise; i++)
      if (rises[i] >= lo) return rises[i+1] - rises[i];
    return -1;
  endfunction

  task automatic count_highs(input int n, output int hb, output int hf);
    hb = 0; hf = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (buzz_o) hb++;
      if (freeze_o) hf++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!buzz_o, "R1 buzz in reset", int'(buzz_o), 0);
    check(!freeze_o, "R1 freeze in reset", int'(freeze_o), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!buzz_o && !freeze_o, "R1 after release", int'({buzz_o, freeze_o}), 0);
  endtask

  task automatic t_chime();
    int t, hb, hf, first_hi;
    pulse_chime();
    first_hi = -1; hf = 0; t = 0;
    while (t < CHIME_MAX + 10) begin
      if (buzz_o && first_hi < 0) first_hi = t;
      if (freeze_o) hf++;
      @(negedge clk); t++;
    end
    check(first_hi >= 0 && first_hi < 10, "R4 chime sounds", first_hi, 2);
    check(hf == 0, "R4 no freeze during chime", hf, 0);
    count_highs(2*STEP, hb, hf);
    check(hb == 0, "R5 silent after chime limit", hb, 0);
  endtask

  task automatic t_tune3();
    int w;
    pulse_alarm();
    send_byte(8'h0E);
    send_byte(8'h00);
    send_byte(8'h3D);   // low nibble 13
    send_byte(8'hFF);
    watch_play(w);
    check(w == 3*STEP, "R8 freeze width three notes", w, 3*STEP);
    check(period_from(0) == 5107, "R2 R3 code 14 period", period_from(0), 5107);
    check(first_fall - rises[0] == 2552, "R2 high width", first_fall - rises[0], 2552);
    check(rest_highs == 0, "R3 rest step silent", rest_highs, 0);
    check(period_from(2*STEP) == 5738, "R6 R3 third note code 13", period_from(2*STEP), 5738);
  endtask

  task automatic t_midplay();
    int w, hb, hf;
    pulse_alarm();
    send_byte(8'h0E);
    send_byte(8'h0E);
    send_byte(8'hFF);
    fork
      watch_play(w);
      begin
        repeat (3000) @(negedge clk);
        chime_i = 1'b1; alarm_i = 1'b1;
        @(negedge clk);
        chime_i = 1'b0; alarm_i = 1'b0;
      end
    join
    check(w == 2*STEP, "R9 playback length kept", w, 2*STEP);
    count_highs(12000, hb, hf);
    check(hb == 0, "R9 no chime after play", hb, 0);
  endtask

  task automatic t_full();
    int w;
    pulse_alarm();
    repeat (DEPTH) send_byte(8'h0E);
    fork
      watch_play(w);
      send_byte(8'hFF);
    join
    check(w == DEPTH*STEP, "R7 full buffer plays", w, DEPTH*STEP);
  endtask

  task automatic t_empty();
    int hb, hf;
    pulse_alarm();
    send_byte(8'hFF);
    count_highs(100, hb, hf);
    check(hf == 0, "R11 no freeze on empty tune", hf, 0);
    send_byte(8'h0E);
    send_byte(8'hFF);
    count_highs(100, hb, hf);
    check(hf == 0 && hb == 0, "R11 idle ignores bytes", hf + hb, 0);
  endtask

  task automatic t_preempt();
    int w;
    pulse_chime();
    repeat (100) @(negedge clk);
    pulse_alarm();
    send_byte(8'h0E);
    send_byte(8'hFF);
    watch_play(w);
    check(w == STEP, "R10 alarm preempts chime", w, STEP);
    check(period_from(0) == 5107, "R10 received note plays", period_from(0), 5107);
  endtask

  initial begin
    t_reset();
    t_chime();
    t_tune3();
    t_midplay();
    t_full();
    t_empty();
    t_preempt();
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < WDOG) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule